// File: doc/BRIEF.md
# Serial EEPROM Byte Fetch Sequencer

This block reads a run of bytes out of a small serial EEPROM on a four-wire SPI-style bus, for example to recover a station address at boot. A host places a start offset and a byte count on its inputs and pulses `start`. The sequencer then drives the active-low select, the serial clock and the outgoing data line, and it samples the incoming data line. It delivers each recovered byte with a one-cycle strobe and pulses `done` one cycle after the last strobe.

Each byte is fetched as a separate transaction. The sequencer asserts select, shifts out the read opcode and the 8-bit address, clocks in eight data bits and then releases select. The address advances by one between transactions. After reset the block first runs a short wake-up pattern, two clock pulses with the device deselected. A status mode sends the status opcode and returns one byte with no address phase. A parameter sets the length of every serial clock phase and every inter-byte gap, counted in system clock cycles.

Top module: `eefetch_seq`

## Requirements
- R1: `mem_cs_n` is 1 during reset and whenever `busy` is low. In reset `mem_sck`, `byte_valid` and `done` are 0.
- R2: After reset the block is busy for one quiet phase and then two serial clock pulses (high, low, high, low) with `mem_cs_n` held at 1. Every `start` during this time is ignored.
- R3: A byte transaction asserts `mem_cs_n` = 0 and shifts out opcode 8'h03 MSB first, then the 8-bit address MSB first, then eight data clocks, for 24 rising edges in total. `mem_mosi` never changes while `mem_sck` is high.
- R4: `mem_miso` is sampled in the last system cycle of the low phase of each data clock, MSB first. The byte appears on `byte_data` during a one-cycle `byte_valid` pulse.
- R5: Byte k of a fetch reads address (offset + k) modulo 256.
- R6: Between transactions `mem_cs_n` is 1 and `mem_sck` is 0 for at least HALF_CYC cycles. Outside the wake-up pattern, the serial clock never pulses while select is 1.
- R7: Every serial clock high phase, and every low phase inside a select window, lasts exactly HALF_CYC system cycles.
- R8: `done` is a one-cycle pulse exactly one cycle after the last `byte_valid`. After it, `busy` is 0.
- R9: A read request with `byte_count` = 0 raises `done` in the cycle after `start` is sampled, with no select activity.
- R10: A `start` while `busy` is 1 has no effect on the bytes produced or on the transactions on the bus.
- R11: With `status_rd` = 1 the block sends opcode 8'h05, gives 16 rising edges in total with no address phase, and returns exactly one byte whatever `byte_count` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| status_rd | input | 1 | 1: read the status byte instead of data |
| start_offset | input | 8 | First byte address |
| byte_count | input | CNT_W | Number of bytes to fetch |
| busy | output | 1 | Sequencer not idle |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Last byte fetched |
| done | output | 1 | One-cycle end-of-request pulse |
| mem_cs_n | output | 1 | Device select, active low |
| mem_sck | output | 1 | Serial clock |
| mem_mosi | output | 1 | Serial data to device |
| mem_miso | input | 1 | Serial data from device |

## Verification
A behavioural device model answers with a computed byte pattern and checks every opcode, address and clock count it receives. The main function is exercised in four ways:
- Single-byte and short multi-byte fetches separate correct data ordering from off-by-one sampling.
- A fetch that crosses address 0xFF exposes a missing modulo wrap.
- A status read with a non-unit count tells the two opcode paths and their address phases apart.
- A zero count, plus start pulses sent during wake-up and during a fetch, show whether requests are ignored rather than queued.

Phase widths and select gaps are measured on every edge, which separates a wrong divider from a wrong sequence.

// File: rtl/eefetch_pkg.sv
package eefetch_pkg;

  localparam int FRAME_W   = 16;
  localparam int DATA_BITS = 8;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;

  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_LOW, ST_HIGH, ST_GAP, ST_LAST, ST_DONE
  } seq_state_t;

  // Outgoing frame, left justified: opcode then address (status: opcode only)
  function automatic logic [FRAME_W-1:0] frame_word(input logic stat,
                                                    input logic [7:0] addr);
    return stat ? {OP_STATUS, 8'h00} : {OP_READ, addr};
  endfunction

  // Total clock slots in one transaction
  function automatic logic [4:0] slot_total(input logic stat);
    return stat ? 5'd16 : 5'd24;
  endfunction

  // Slots at or beyond the command length carry incoming data
  function automatic logic is_data_slot(input logic [4:0] slot, input logic stat);
    return slot >= (stat ? 5'd8 : 5'd16);
  endfunction

  function automatic logic [7:0] next_addr(input logic [7:0] a);
    return a + 8'd1;
  endfunction

endpackage

// File: rtl/eefetch_timer.sv
module eefetch_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  generate
    if (HALF_CYC > 1) begin : g_spacing
      // R7
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/eefetch_shift.sv
module eefetch_shift
  import eefetch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               advance,
  input  logic               capture,
  input  logic               miso,
  output logic               mosi,
  output logic [DATA_BITS-1:0] rx_byte
);
  logic [FRAME_W-1:0]   tx_sr;
  logic [DATA_BITS-1:0] rx_sr;

  assign mosi    = tx_sr[FRAME_W-1];
  assign rx_byte = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_sr <= '0;
    else if (load)    tx_sr <= load_word;
    else if (advance) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_sr <= '0;
    else if (capture) rx_sr <= {rx_sr[DATA_BITS-2:0], miso};
  end

  // R4
  shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && (advance || load)));

endmodule

// File: rtl/eefetch_seq.sv
module eefetch_seq
  import eefetch_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             status_rd,
  input  logic [7:0]       start_offset,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             done,
  output logic             mem_cs_n,
  output logic             mem_sck,
  output logic             mem_mosi,
  input  logic             mem_miso
);
  localparam logic [2:0] INIT_LAST = 3'd4;

  seq_state_t       state;
  logic [2:0]       init_idx;
  logic [4:0]       slot;
  logic             stat_q;
  logic [7:0]       addr_q;
  logic [CNT_W-1:0] left_q;
  logic             valid_q;
  logic [7:0]       data_q;
  logic             tick;
  logic [7:0]       rx_byte;

  // Named internal events
  wire run_phase  = (state == ST_INIT) || (state == ST_LOW) ||
                    (state == ST_HIGH) || (state == ST_GAP);
  wire accept     = (state == ST_IDLE) && start;
  wire zero_req   = accept && !status_rd && (byte_count == '0);
  wire load_first = accept && !zero_req;
  wire low_end    = (state == ST_LOW)  && tick;
  wire high_end   = (state == ST_HIGH) && tick;
  wire gap_end    = (state == ST_GAP)  && tick;
  wire last_slot  = (slot == slot_total(stat_q) - 5'd1);
  wire last_byte  = (left_q == CNT_W'(1));
  wire capture_evt = low_end && is_data_slot(slot, stat_q);
  wire advance_evt = high_end && !last_slot;
  wire reload_evt  = gap_end && !last_byte;
  wire load_evt    = load_first || reload_evt;
  wire [FRAME_W-1:0] load_word = load_first ? frame_word(status_rd, start_offset)
                                            : frame_word(stat_q, next_addr(addr_q));

  eefetch_timer #(.HALF_CYC(HALF_CYC)) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_phase),
    .tick (tick)
  );

  eefetch_shift shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_word(load_word),
    .advance  (advance_evt),
    .capture  (capture_evt),
    .miso     (mem_miso),
    .mosi     (mem_mosi),
    .rx_byte  (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_INIT;
      init_idx <= '0;
      slot     <= '0;
      stat_q   <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
      valid_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      valid_q <= gap_end;
      if (gap_end) data_q <= rx_byte;
      unique case (state)
        ST_INIT: if (tick) begin
          if (init_idx == INIT_LAST) state <= ST_IDLE;
          else                       init_idx <= init_idx + 3'd1;
        end
        ST_IDLE: begin
          if (zero_req) state <= ST_DONE;
          else if (load_first) begin
            stat_q <= status_rd;
            addr_q <= start_offset;
            left_q <= status_rd ? CNT_W'(1) : byte_count;
            slot   <= '0;
            state  <= ST_LOW;
          end
        end
        ST_LOW: if (tick) state <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (last_slot) state <= ST_GAP;
          else begin
            slot  <= slot + 5'd1;
            state <= ST_LOW;
          end
        end
        ST_GAP: if (tick) begin
          left_q <= left_q - CNT_W'(1);
          if (last_byte) state <= ST_LAST;
          else begin
            addr_q <= next_addr(addr_q);
            slot   <= '0;
            state  <= ST_LOW;
          end
        end
        ST_LAST: state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign byte_valid = valid_q;
  assign byte_data  = data_q;
  assign mem_sck    = (state == ST_HIGH) || ((state == ST_INIT) && init_idx[0]);
  assign mem_cs_n   = !((state == ST_LOW) || (state == ST_HIGH));

  // R1
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mem_cs_n);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sck && $past(mem_sck)) |-> $stable(mem_mosi));

  // R4
  sample_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> (!mem_sck && !mem_cs_n));

  // R8
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(byte_valid) || $past(zero_req)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !gap_end) |=> $stable(left_q));

endmodule

// File: tb/eefetch_seq_tb_top.sv
module eefetch_seq_tb_top;
  localparam int HALF = 4;
  localparam int CW   = 8;
  localparam logic [7:0] STATUS_VAL = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, status_rd = 1'b0;
  logic [7:0] start_offset = '0;
  logic [CW-1:0] byte_count = '0;
  logic busy, byte_valid, done, mem_cs_n, mem_sck, mem_mosi;
  logic mem_miso = 1'b0;
  logic [7:0] byte_data;

  always #4 clk = ~clk;

  eefetch_seq #(.HALF_CYC(HALF), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .status_rd(status_rd),
    .start_offset(start_offset), .byte_count(byte_count), .busy(busy),
    .byte_valid(byte_valid), .byte_data(byte_data), .done(done),
    .mem_cs_n(mem_cs_n), .mem_sck(mem_sck), .mem_mosi(mem_mosi),
    .mem_miso(mem_miso));

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_f(input logic [7:0] a);
    logic [7:0] t;
    t = a * 8'd37;
    return t ^ 8'hA5;
  endfunction

  // Scoreboard queues
  logic [7:0] exp_q[$];
  logic [7:0] addr_exp[$];
  logic [7:0] exp_op = 8'h03;
  int exp_clocks = 24;

  // Device model
  int m_cnt = 0, txn_cnt = 0, init_rises = 0;
  logic [15:0] m_in = '0;
  logic [7:0]  m_out = '0;
  logic m_stat = 1'b0, m_seen = 1'b0;

  always @(negedge mem_cs_n) if (rst_n) begin
    m_cnt = 0; m_in = '0; m_stat = 1'b0; m_seen = 1'b1; txn_cnt++;
  end

  always @(posedge mem_sck) begin
    if (rst_n && mem_cs_n) init_rises++;
    else if (rst_n && !mem_cs_n) begin
      m_in = {m_in[14:0], mem_mosi};
      m_cnt++;
      if (m_cnt == 8) begin
        chk(m_in[7:0] == exp_op, "R3/R11", "opcode", m_in[7:0], exp_op);
        if (m_in[7:0] == 8'h05) begin m_stat = 1'b1; m_out = STATUS_VAL; end
      end
      if (m_cnt == 16 && !m_stat) begin
        m_out = mem_f(m_in[7:0]);
        if (addr_exp.size() == 0) chk(0, "R5", "address without request", m_in[7:0], 0);
        else begin
          logic [7:0] ea;
          ea = addr_exp.pop_front();
          chk(m_in[7:0] == ea, "R5", "address", m_in[7:0], ea);
        end
      end
    end
  end

  always @(negedge mem_sck) if (rst_n && !mem_cs_n) begin
    if ((m_stat && m_cnt >= 8) || m_cnt >= 16) begin
      mem_miso = m_out[7];
      m_out = {m_out[6:0], 1'b0};
    end
  end

  always @(posedge mem_cs_n) if (rst_n && m_seen)
    chk(m_cnt == exp_clocks, "R3/R11", "clocks per transaction", m_cnt, exp_clocks);

  // Monitor: bytes, done timing, phase widths
  logic prev_valid = 1'b0;
  logic zero_exp = 1'b0;
  int done_cnt = 0, hi_run = 0, lo_run = 0, sh_run = 0, ph_bad = 0, gap_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin
      if (exp_q.size() == 0) chk(0, "R10", "unexpected byte", byte_data, 0);
      else begin
        logic [7:0] eb;
        eb = exp_q.pop_front();
        chk(byte_data == eb, "R4", "byte value", byte_data, eb);
      end
    end
    if (done) begin
      done_cnt++;
      // R8: done follows the last strobe by one cycle
      if (!zero_exp) chk(prev_valid == 1'b1, "R8", "done after strobe", prev_valid, 1);
    end
    prev_valid = byte_valid;
    // R7 phase widths
    if (mem_sck) hi_run++;
    else if (hi_run != 0) begin if (hi_run != HALF) ph_bad++; hi_run = 0; end
    if (!mem_sck && !mem_cs_n) lo_run++;
    else if (mem_sck && lo_run != 0) begin if (lo_run != HALF) ph_bad++; lo_run = 0; end
    else lo_run = 0;
    // R6 select gap
    if (mem_cs_n) sh_run++;
    else if (sh_run != 0) begin if (sh_run < HALF) gap_bad++; sh_run = 0; end
  end

  // Driver
  task automatic fetch(input logic [7:0] off, input int cnt, input bit stat,
                       input bit interfere);
    int nb, t0, d0;
    while (busy) @(negedge clk);
    nb = stat ? 1 : cnt;
    for (int i = 0; i < nb; i++) begin
      if (stat) exp_q.push_back(STATUS_VAL);
      else begin
        exp_q.push_back(mem_f(off + 8'(i)));
        addr_exp.push_back(off + 8'(i));
      end
    end
    exp_op = stat ? 8'h05 : 8'h03;
    exp_clocks = stat ? 16 : 24;
    zero_exp = (nb == 0);
    t0 = txn_cnt; d0 = done_cnt;
    start_offset = off; byte_count = CW'(cnt); status_rd = stat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (nb == 0) begin
      chk(done == 1'b1, "R9", "done one cycle after zero request", done, 1);
      chk(mem_cs_n == 1'b1, "R9", "select idle", mem_cs_n, 1);
    end
    if (interfere) begin
      repeat (60) @(negedge clk);
      start_offset = 8'h80; byte_count = CW'(5); status_rd = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 20000 && done_cnt == d0; k++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8", "done count", done_cnt - d0, 1);
    @(negedge clk);
    chk(!busy, "R8", "idle after done", busy, 0);
    chk(exp_q.size() == 0, "R4", "bytes outstanding", exp_q.size(), 0);
    chk(txn_cnt - t0 == nb, "R3", "transactions", txn_cnt - t0, nb);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n == 1'b1, "R1", "select in reset", mem_cs_n, 1);
    chk(mem_sck == 1'b0, "R1", "clock in reset", mem_sck, 0);
    chk(byte_valid == 1'b0 && done == 1'b0, "R1", "strobes in reset", byte_valid + done, 0);
    rst_n = 1'b1;
    // R2: start during wake-up ignored
    byte_count = CW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    chk(!busy, "R2", "wake-up finished", busy, 0);
    chk(init_rises == 2, "R2", "wake-up pulses", init_rises, 2);
    chk(txn_cnt == 0, "R2", "no select during wake-up", txn_cnt, 0);
    repeat (50) @(negedge clk);
    chk(txn_cnt == 0, "R10", "no fetch from ignored start", txn_cnt, 0);

    fetch(8'h00, 1, 1'b0, 1'b0);   // R3 R4 single byte
    fetch(8'h10, 3, 1'b0, 1'b0);   // R5 run
    fetch(8'hFC, 6, 1'b0, 1'b0);   // R5 wrap
    fetch(8'hFF, 2, 1'b0, 1'b0);   // R5 wrap at first step
    fetch(8'h00, 4, 1'b1, 1'b0);   // R11 status, count ignored
    fetch(8'h20, 0, 1'b0, 1'b0);   // R9 zero count
    fetch(8'h40, 3, 1'b0, 1'b1);   // R10 start while busy
    begin
      int t0;
      t0 = txn_cnt;
      repeat (400) @(negedge clk);
      chk(txn_cnt == t0 && !busy, "R10", "nothing after ignored start", txn_cnt - t0, 0);
    end
    chk(init_rises == 2, "R6", "no clock while deselected", init_rises, 2);
    chk(ph_bad == 0, "R7", "phase width errors", ph_bad, 0);
    chk(gap_bad == 0, "R6", "select gap errors", gap_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule